// File: doc/BRIEF.md
# Bank Open/Closed State Tracker

This block sits on the controller side of a four-bank DDR SDRAM interface. It watches the stream of decoded commands and keeps, for every bank, whether that bank is idle, holds an open row, or is still closing. Each command arrives as a code together with a bank number and the auto-all address bit. Every cycle the block reports whether the presented command is allowed in the current bank states.

A close command either targets one bank, chosen by the bank number, or targets every bank when the address bit is high. In the second case the bank number is ignored. Each bank that closes loads a programmable row-precharge count into its own down-counter. The bank does not count as idle, and cannot accept a new row open, until that counter has run out. Read and write are allowed only to a bank with an open row. A command that is not allowed changes no bank state.

Top module: `bank_state_tracker`

## Requirements
- R1: After reset every bank reports idle (status code 2'b00) and `all_idle_o` is high.
- R2: A PRECHARGE (code 4) with `a10_i` high puts every bank into the closing state, whatever `bank_i` holds.
- R3: A PRECHARGE with `a10_i` low changes only the bank numbered by `bank_i`. Bank b's status sits in `bank_state_o[2b+1:2b]`.
- R4: When PRECHARGE is issued at edge k with `trp_cycles_i` = T > 0, the bank reports closing (2'b10) after edges k to k+T-1 and idle from edge k+T on. With T = 0 the bank is idle right after edge k.
- R5: An ACTIVATE (code 1) to an idle bank is legal, and the bank reports active (2'b01) after that edge.
- R6: An ACTIVATE to a bank that is active or closing is illegal and changes no bank state.
- R7: READ (code 2) and WRITE (code 3) are legal only to an active bank and never change bank state.
- R8: A PRECHARGE to an idle or closing bank is legal and restarts that bank's count from `trp_cycles_i`.
- R9: `all_idle_o` is high exactly when every bank is idle with its counter at zero.
- R10: NOP (code 0) is legal and changes nothing. Codes 5 to 7 are illegal and change nothing.
- R11: `cmd_legal_o` reflects, in the same cycle, whether the command now on the inputs is allowed in the current bank states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE |
| bank_i | input | 2 | Target bank number |
| a10_i | input | 1 | High on PRECHARGE selects all banks |
| trp_cycles_i | input | 4 | Row-precharge count loaded on PRECHARGE |
| bank_state_o | output | 8 | Two status bits per bank: 00 idle, 01 active, 10 closing |
| all_idle_o | output | 1 | Every bank idle |
| cmd_legal_o | output | 1 | Current command allowed |

## Verification
The bench uses the default build: four banks and a 4-bit count. This keeps the whole per-bank state space small. A long biased random command stream, repeated for row-precharge values 0 to 5 and 15, drives every bank through every transition many times. It covers zero-length waits, restarts in the middle of a count, and all-bank closes landing on banks in mixed states. A small arithmetic model in the bench predicts legality, the packed status and the all-idle flag on every cycle. Directed sequences pin the exact length of the closing window and the restart behaviour.

// File: rtl/bank_trk_pkg.sv
`timescale 1ns/1ps
package bank_trk_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_OPEN  = 2'b01,
    ST_CLOSE = 2'b10
  } bank_st_e;
endpackage

// File: rtl/bank_trk_decode.sv
`timescale 1ns/1ps
module bank_trk_decode
  import bank_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic [BA_W-1:0]      bank_i,
  input  logic                 a10_i,
  input  logic [NUM_BANKS-1:0] idle_i,
  input  logic [NUM_BANKS-1:0] open_i,
  output logic                 legal_o,
  output logic [NUM_BANKS-1:0] act_sel_o,
  output logic [NUM_BANKS-1:0] pre_sel_o
);
  logic [NUM_BANKS-1:0] tgt;

  always_comb begin
    tgt = '0;
    tgt[bank_i] = 1'b1;
  end

  always_comb begin
    legal_o   = 1'b0;
    act_sel_o = '0;
    pre_sel_o = '0;
    case (cmd_i)
      CMD_NOP: legal_o = 1'b1;
      CMD_ACT: begin
        legal_o   = idle_i[bank_i];
        act_sel_o = legal_o ? tgt : '0;
      end
      CMD_RD, CMD_WR: legal_o = open_i[bank_i];
      CMD_PRE: begin
        legal_o   = 1'b1;
        pre_sel_o = a10_i ? '1 : tgt;
      end
      default: legal_o = 1'b0;
    endcase
  end

  p_pre_all_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_PRE && a10_i) |-> (&pre_sel_o));
  p_pre_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_PRE && !a10_i) |-> ($countones(pre_sel_o) == 1));
  p_act_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_sel_o));
endmodule

// File: rtl/bank_trk_slot.sv
`timescale 1ns/1ps
module bank_trk_slot
  import bank_trk_pkg::*;
#(
  parameter int TRP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [TRP_W-1:0] trp_i,
  output bank_st_e         state_o,
  output logic             cnt_zero_o
);
  bank_st_e         state_q;
  logic [TRP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (pre_i) begin
      cnt_q   <= trp_i;
      state_q <= (trp_i == '0) ? ST_IDLE : ST_CLOSE;
    end else if (act_i) begin
      state_q <= ST_OPEN;
    end else if (state_q == ST_CLOSE) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == TRP_W'(1)) state_q <= ST_IDLE;
    end
  end

  assign state_o    = state_q;
  assign cnt_zero_o = (cnt_q == '0);

  p_pre_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |=> (cnt_q == $past(trp_i)));
  p_count_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pre_i && state_q == ST_CLOSE) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_act_from_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> (state_q == ST_IDLE));
  p_open_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPEN && !pre_i) |=> (state_q == ST_OPEN));
  p_idle_cnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (cnt_q == '0));
endmodule

// File: rtl/bank_state_tracker.sv
`timescale 1ns/1ps
module bank_state_tracker
  import bank_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRP_W     = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2:0]             cmd_i,
  input  logic [BA_W-1:0]        bank_i,
  input  logic                   a10_i,
  input  logic [TRP_W-1:0]       trp_cycles_i,
  output logic [2*NUM_BANKS-1:0] bank_state_o,
  output logic                   all_idle_o,
  output logic                   cmd_legal_o
);
  logic [NUM_BANKS-1:0] idle_v, open_v, close_v, zero_v, act_sel, pre_sel;

  bank_trk_decode #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) i_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd_i),
    .bank_i    (bank_i),
    .a10_i     (a10_i),
    .idle_i    (idle_v),
    .open_i    (open_v),
    .legal_o   (cmd_legal_o),
    .act_sel_o (act_sel),
    .pre_sel_o (pre_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_st_e st;
    bank_trk_slot #(.TRP_W(TRP_W)) i_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (act_sel[b]),
      .pre_i      (pre_sel[b]),
      .trp_i      (trp_cycles_i),
      .state_o    (st),
      .cnt_zero_o (zero_v[b])
    );
    assign idle_v[b]  = (st == ST_IDLE);
    assign open_v[b]  = (st == ST_OPEN);
    assign close_v[b] = (st == ST_CLOSE);
    assign bank_state_o[2*b+1:2*b] = st;
  end

  assign all_idle_o = &(idle_v & zero_v);

  p_all_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_idle_o |-> ((&zero_v) && (open_v == '0) && (close_v == '0)));
  p_illegal_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_legal_o && close_v == '0) |=> $stable(bank_state_o));
  p_rdwr_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i == CMD_RD || cmd_i == CMD_WR) && close_v == '0) |=> $stable(bank_state_o));
  p_nop_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_NOP && close_v == '0) |=> $stable(bank_state_o));
endmodule

// File: tb/test_bank_state_tracker.sv
`timescale 1ns/1ps
module test_bank_state_tracker;
  localparam int NB = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic [1:0] bank_i = 2'd0;
  logic       a10_i = 1'b0;
  logic [3:0] trp_cycles_i = 4'd0;
  logic [7:0] bank_state_o;
  logic       all_idle_o, cmd_legal_o;

  int n_chk = 0, n_fail = 0;
  int m_st[NB];
  int m_cnt[NB];

  always #2.5 clk = ~clk;

  bank_state_tracker i_bank_state_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .bank_i(bank_i), .a10_i(a10_i),
    .trp_cycles_i(trp_cycles_i), .bank_state_o(bank_state_o),
    .all_idle_o(all_idle_o), .cmd_legal_o(cmd_legal_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic m_legal(input int c, input int b);
    case (c)
      0, 4: return 1'b1;
      1: return m_st[b] == 0;
      2, 3: return m_st[b] == 1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] m_pack();
    logic [7:0] v = '0;
    for (int b = 0; b < NB; b++) v[2*b +: 2] = 2'(m_st[b]);
    return v;
  endfunction

  function automatic logic m_all_idle();
    for (int b = 0; b < NB; b++) if (m_st[b] != 0 || m_cnt[b] != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic issue(input int c, input int b, input logic a, input string tag);
    logic lg;
    @(negedge clk);
    cmd_i = 3'(c); bank_i = 2'(b); a10_i = a;
    #0.5;
    lg = m_legal(c, b);
    chk("R11 legal", cmd_legal_o, lg);
    @(posedge clk);
    for (int k = 0; k < NB; k++) begin
      if (lg && c == 4 && (a || k == b)) begin
        m_cnt[k] = int'(trp_cycles_i);
        m_st[k]  = (m_cnt[k] == 0) ? 0 : 2;
      end else if (lg && c == 1 && k == b) begin
        m_st[k] = 1;
      end else if (m_st[k] == 2) begin
        m_cnt[k]--;
        if (m_cnt[k] == 0) m_st[k] = 0;
      end
    end
    #1;
    chk(tag, bank_state_o, m_pack());
    chk("R9 all_idle", all_idle_o, m_all_idle());
  endtask

  function automatic string tag_of(input int c, input logic a, input logic lg);
    case (c)
      0: return "R10 nop";
      1: return lg ? "R5 act" : "R6 act_illegal";
      2, 3: return "R7 rdwr";
      4: return a ? "R2 pre_all" : "R3 pre_one";
      default: return "R10 bad_code";
    endcase
  endfunction

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_cnt[b] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset state", bank_state_o, 8'h00);
    chk("R1 reset all_idle", all_idle_o, 1'b1);
    @(negedge clk) rst_ni = 1'b1;

    // R4: exact closing window length, T = 3
    trp_cycles_i = 4'd3;
    issue(1, 0, 1'b0, "R5 act");
    issue(4, 2, 1'b1, "R2 pre_all");
    chk("R4 closing after edge k", bank_state_o[1:0], 2'b10);
    issue(1, 0, 1'b0, "R6 act while closing");
    chk("R4 closing after k+1", bank_state_o[1:0], 2'b10);
    issue(0, 0, 1'b0, "R10 nop");
    chk("R4 closing after k+2", bank_state_o[1:0], 2'b10);
    issue(0, 0, 1'b0, "R10 nop");
    chk("R4 idle after k+3", bank_state_o[1:0], 2'b00);
    chk("R9 all idle after window", all_idle_o, 1'b1);

    // R8: precharge to idle bank, then restart mid-count
    issue(4, 1, 1'b0, "R8 pre idle bank");
    issue(0, 0, 1'b0, "R10 nop");
    issue(4, 1, 1'b0, "R8 restart");
    issue(0, 0, 1'b0, "R10 nop");
    issue(0, 0, 1'b0, "R10 nop");
    chk("R8 still closing after restart", bank_state_o[3:2], 2'b10);
    issue(0, 0, 1'b0, "R10 nop");
    chk("R8 idle after restarted window", bank_state_o[3:2], 2'b00);

    // R4: zero count closes at once
    trp_cycles_i = 4'd0;
    issue(1, 3, 1'b0, "R5 act");
    issue(4, 3, 1'b0, "R3 pre_one");
    chk("R4 T=0 idle at once", bank_state_o[7:6], 2'b00);

    // Sweeps over counts with biased random commands
    foreach (m_cnt[i]) ;
    for (int t = 0; t < 7; t++) begin
      trp_cycles_i = (t == 6) ? 4'd15 : 4'(t);
      for (int n = 0; n < 1500; n++) begin
        int c, b;
        logic a;
        c = ($urandom_range(0, 9) < 8) ? $urandom_range(0, 4) : $urandom_range(0, 7);
        b = $urandom_range(0, NB - 1);
        a = ($urandom_range(0, 5) == 0);
        issue(c, b, a, tag_of(c, a, m_legal(c, b)));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule